// File: doc/BRIEF.md
# Voltage ID Input Qualifier

This block sits between a parallel voltage-identification code bus and the reference logic of a regulator. It reads the bus on every rising edge of its sample clock, which runs at about 5.5 MHz. A value becomes the new validated target only after it has read the same on several consecutive samples. A short disturbance on the bus therefore never reaches the reference.

Two run lengths apply. An ordinary code is accepted after three equal samples, and acceptance is reported by a one-cycle update pulse. A code that matches the reserved "off" pattern of the current mode needs four equal samples. That code never becomes a target. Instead it sets a regulation-disable flag, which stays set until the enable input is taken low.

The mode input selects between a six-bit table with direct update and a five-bit table with slewed update. In five-bit mode the top bit of the bus is ignored. Each mode has its own off pattern, supplied on an input.

Top module: `vid_qualifier`

## Requirements
- R1: While the synchronous active-high `rst` is high at a clock edge, `target` clears to 0 and `update` and `reg_off` clear to 0.
- R2: While `en` is high, the masked bus value is sampled at every clock edge. An ordinary code is accepted only after it has been sampled on 3 consecutive edges. At the next edge, `target` takes the code and `update` goes high. A run of 1 or 2 samples changes nothing.
- R3: `update` is high for exactly one cycle per acceptance, even when the code is held for many more samples.
- R4: A code that is accepted while equal to the current `target` raises no `update` pulse.
- R5: A code equal to the off pattern of the current mode must be sampled on 4 consecutive edges. One edge later, `reg_off` goes high. With only 3 samples it stays low. An off code never becomes `target`.
- R6: While `reg_off` is high, bus activity neither changes `target` nor raises `update`.
- R7: An edge with `en` low clears `reg_off` and the run count and blocks `update`, while `target` keeps its value. Counting restarts at one on the first edge with `en` high.
- R8: With `mode` = 0, all 6 bits are sampled and compared with `off_code_direct`. With `mode` = 1, bit 5 is forced to 0 in the sampled code and in `target`, and only bits 4:0 are compared with `off_code_slew`.
- R9: Off detection depends on the mode. A bus value that is the off code of one mode is handled as an ordinary code in the other mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, about 5.5 MHz |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Enable; low clears the off latch and the counters |
| mode | input | 1 | 0: six-bit direct table, 1: five-bit slewed table |
| vid | input | 6 | Voltage-identification code bus |
| off_code_direct | input | 6 | Off pattern for mode 0 |
| off_code_slew | input | 6 | Off pattern for mode 1 (bits 4:0 used) |
| target | output | 6 | Last validated code |
| update | output | 1 | One-cycle pulse when `target` takes a new code |
| reg_off | output | 1 | Latched regulation-disable flag |

## Verification
Single-sample and double-sample glitches are driven between held codes. They show that the three-sample rule is applied, and not a plain edge detector. An off code held for three samples is followed by one held for four. This separates the two run lengths, and bus activity after the latch shows that the latch is sticky. Top-bit toggles in five-bit mode and off codes applied in the wrong mode show the masking and the mode-dependent matching. Long random runs of holds, changes, enable drops and mode flips are checked cycle by cycle against a bench model.

// File: rtl/vidq_pkg.sv
`timescale 1ns/1ps
package vidq_pkg;
  typedef enum logic {
    MODE_DIRECT = 1'b0,
    MODE_SLEW   = 1'b1
  } vid_mode_e;

  function automatic int run_width(input int max_run);
    return $clog2(max_run + 1);
  endfunction
endpackage

// File: rtl/vidq_sampler.sv
`timescale 1ns/1ps
module vidq_sampler #(
  parameter int VID_W   = 6,
  parameter int SHORT_W = 5,
  parameter int OFF_RUN = 4,
  localparam int RW     = vidq_pkg::run_width(OFF_RUN)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             five_bit,
  input  logic [VID_W-1:0] vid,
  output logic [VID_W-1:0] smp_q,
  output logic [RW-1:0]    run_q
);
  logic [VID_W-1:0] masked;

  for (genvar i = 0; i < VID_W; i++) begin : g_mask
    if (i >= SHORT_W) begin : g_hi
      assign masked[i] = vid[i] & ~five_bit;
    end else begin : g_lo
      assign masked[i] = vid[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      smp_q <= '0;
      run_q <= '0;
    end else begin
      smp_q <= masked;
      if (run_q != '0 && masked == smp_q) begin
        if (run_q != RW'(OFF_RUN)) run_q <= run_q + 1'b1;
      end else begin
        run_q <= RW'(1);
      end
    end
  end

  // R7: a disabled edge empties the run counter
  a_r7_idle_clears: assert property (@(posedge clk) disable iff (rst)
    !en |=> run_q == '0);
  // R2: a differing sample restarts the run at one
  a_r2_change_restarts: assert property (@(posedge clk) disable iff (rst)
    (en && masked != smp_q) |=> run_q == RW'(1));
  // R2: an equal sample grows an unsaturated run by one
  a_r2_hold_grows: assert property (@(posedge clk) disable iff (rst)
    (en && run_q != '0 && masked == smp_q && run_q < RW'(OFF_RUN))
      |=> run_q == $past(run_q) + 1'b1);
endmodule

// File: rtl/vidq_off_match.sv
`timescale 1ns/1ps
module vidq_off_match #(
  parameter int VID_W   = 6,
  parameter int SHORT_W = 5
) (
  input  logic             five_bit,
  input  logic [VID_W-1:0] code,
  input  logic [VID_W-1:0] off_direct,
  input  logic [VID_W-1:0] off_slew,
  output logic             hit
);
  logic [VID_W-1:0] care;
  logic [VID_W-1:0] pattern;

  for (genvar i = 0; i < VID_W; i++) begin : g_care
    if (i >= SHORT_W) begin : g_hi
      assign care[i] = ~five_bit;
    end else begin : g_lo
      assign care[i] = 1'b1;
    end
  end

  always_comb begin
    pattern = five_bit ? off_slew : off_direct;
    hit     = ((code ^ pattern) & care) == '0;
  end
endmodule

// File: rtl/vidq_accept.sv
`timescale 1ns/1ps
module vidq_accept #(
  parameter int VID_W    = 6,
  parameter int NORM_RUN = 3,
  parameter int OFF_RUN  = 4,
  localparam int RW      = vidq_pkg::run_width(OFF_RUN)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [VID_W-1:0] smp_q,
  input  logic [RW-1:0]    run_q,
  input  logic             off_hit,
  output logic [VID_W-1:0] target_q,
  output logic             upd_q,
  output logic             off_q
);
  logic take_norm;
  logic take_off;

  always_comb begin
    take_norm = en && !off_q && !off_hit && run_q == RW'(NORM_RUN) && smp_q != target_q;
    take_off  = en && off_hit && run_q == RW'(OFF_RUN);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      target_q <= '0;
      upd_q    <= 1'b0;
      off_q    <= 1'b0;
    end else begin
      upd_q <= take_norm;
      if (take_norm) target_q <= smp_q;
      if (!en)           off_q <= 1'b0;
      else if (take_off) off_q <= 1'b1;
    end
  end

  // R3: a pulse never lasts two cycles
  a_r3_pulse_once: assert property (@(posedge clk) disable iff (rst)
    upd_q |=> !upd_q);
  // R4: every pulse comes with a different target
  a_r4_target_moves: assert property (@(posedge clk) disable iff (rst)
    upd_q |-> target_q != $past(target_q));
  // R5: the latch only sets after a full off-length run of an off code
  a_r5_off_run: assert property (@(posedge clk) disable iff (rst)
    $rose(off_q) |-> ($past(run_q) == RW'(OFF_RUN) && $past(off_hit)));
  // R6: while latched the target is frozen and silent
  a_r6_latched_frozen: assert property (@(posedge clk) disable iff (rst)
    off_q |=> ($stable(target_q) && !upd_q));
  // R7: enable low clears the latch and blocks pulses
  a_r7_disable_clears: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!off_q && !upd_q));
endmodule

// File: rtl/vid_qualifier.sv
`timescale 1ns/1ps
module vid_qualifier #(
  parameter int VID_W    = 6,
  parameter int SHORT_W  = 5,
  parameter int NORM_RUN = 3,
  parameter int OFF_RUN  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             mode,
  input  logic [VID_W-1:0] vid,
  input  logic [VID_W-1:0] off_code_direct,
  input  logic [VID_W-1:0] off_code_slew,
  output logic [VID_W-1:0] target,
  output logic             update,
  output logic             reg_off
);
  localparam int RW = vidq_pkg::run_width(OFF_RUN);

  vidq_pkg::vid_mode_e mode_e;
  logic                five_bit;
  logic [VID_W-1:0]    smp_q;
  logic [RW-1:0]       run_q;
  logic                off_hit;

  assign mode_e   = vidq_pkg::vid_mode_e'(mode);
  assign five_bit = (mode_e == vidq_pkg::MODE_SLEW);

  vidq_sampler #(.VID_W(VID_W), .SHORT_W(SHORT_W), .OFF_RUN(OFF_RUN)) u_sampler (
    .clk(clk), .rst(rst), .en(en), .five_bit(five_bit), .vid(vid),
    .smp_q(smp_q), .run_q(run_q)
  );

  vidq_off_match #(.VID_W(VID_W), .SHORT_W(SHORT_W)) u_match (
    .five_bit(five_bit), .code(smp_q), .off_direct(off_code_direct),
    .off_slew(off_code_slew), .hit(off_hit)
  );

  vidq_accept #(.VID_W(VID_W), .NORM_RUN(NORM_RUN), .OFF_RUN(OFF_RUN)) u_accept (
    .clk(clk), .rst(rst), .en(en), .smp_q(smp_q), .run_q(run_q),
    .off_hit(off_hit), .target_q(target), .upd_q(update), .off_q(reg_off)
  );
endmodule

// File: tb/tb_vid_qualifier.sv
`timescale 1ns/1ps
module tb_vid_qualifier;
  logic       clk = 1'b0;
  logic       rst, en, mode;
  logic [5:0] vid, off_code_direct, off_code_slew;
  logic [5:0] target;
  logic       update, reg_off;

  int n_chk = 0, n_fail = 0, pulses = 0;
  logic [5:0] m_smp, m_tgt;
  int         m_run;
  logic       m_upd, m_off;

  always #2.5 clk = ~clk;

  vid_qualifier dut (
    .clk(clk), .rst(rst), .en(en), .mode(mode), .vid(vid),
    .off_code_direct(off_code_direct), .off_code_slew(off_code_slew),
    .target(target), .update(update), .reg_off(reg_off)
  );

  function automatic logic [5:0] mask_code(logic [5:0] c, logic m);
    return m ? {1'b0, c[4:0]} : c;
  endfunction

  function automatic logic is_off(logic [5:0] c, logic m);
    return m ? (c[4:0] == off_code_slew[4:0]) : (c == off_code_direct);
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic model_step();
    logic [5:0] n_tgt, mc;
    logic n_upd, n_off;
    if (rst) begin
      m_smp = '0; m_run = 0; m_tgt = '0; m_upd = 0; m_off = 0;
    end else begin
      n_tgt = m_tgt; n_upd = 0; n_off = m_off;
      if (!en) begin
        n_off = 0; m_smp = '0; m_run = 0;
      end else begin
        if (m_run == 3 && !is_off(m_smp, mode) && !m_off && m_smp != m_tgt) begin
          n_tgt = m_smp; n_upd = 1;
        end
        if (m_run == 4 && is_off(m_smp, mode)) n_off = 1;
        mc = mask_code(vid, mode);
        m_run = (m_run != 0 && mc == m_smp) ? ((m_run == 4) ? 4 : m_run + 1) : 1;
        m_smp = mc;
      end
      m_tgt = n_tgt; m_upd = n_upd; m_off = n_off;
    end
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    if (update) pulses++;
    chk("R2 model target", target, m_tgt);
    chk("R3 model update", update, m_upd);
    chk("R5 model reg_off", reg_off, m_off);
  endtask

  task automatic hold(logic [5:0] code, int n);
    vid = code;
    repeat (n) tick();
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(5.0 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int unsigned seed_v;
    seed_v = $urandom(32'd4711);
    rst = 1; en = 1; mode = 0; vid = 0;
    off_code_direct = 6'h3F; off_code_slew = 6'h1F;
    @(negedge clk);
    tick(); tick();
    rst = 0;
    chk("R1 reset target", target, 0);
    chk("R1 reset update", update, 0);
    chk("R1 reset reg_off", reg_off, 0);

    hold(6'd5, 6);
    chk("R2 held code accepted", target, 5);
    pulses = 0;
    hold(6'd12, 1); hold(6'd5, 4);
    chk("R2 one-sample glitch target", target, 5);
    chk("R2 one-sample glitch pulses", pulses, 0);
    hold(6'd12, 2); hold(6'd5, 4);
    chk("R2 two-sample glitch target", target, 5);
    chk("R2 two-sample glitch pulses", pulses, 0);
    hold(6'd12, 3);
    chk("R2 not yet after three edges", target, 5);
    hold(6'd12, 1);
    chk("R2 pulse one edge later", update, 1);
    chk("R2 target one edge later", target, 12);
    pulses = 0;
    hold(6'd12, 6);
    chk("R3 no repeat pulse", pulses, 0);
    hold(6'd20, 1); hold(6'd12, 5);
    chk("R4 equal code no pulse", pulses, 0);

    hold(6'h3F, 3); hold(6'd7, 2);
    chk("R5 three-sample off rejected", reg_off, 0);
    chk("R5 off never target", target, 12);
    hold(6'd7, 4);
    chk("R2 code seven accepted", target, 7);
    hold(6'h3F, 4);
    chk("R5 not latched after four edges", reg_off, 0);
    hold(6'h3F, 1);
    chk("R5 four-sample off latched", reg_off, 1);
    pulses = 0;
    hold(6'd33, 6);
    chk("R6 latched target frozen", target, 7);
    chk("R6 latched no pulses", pulses, 0);
    chk("R6 latch sticky", reg_off, 1);

    en = 0; tick(); tick();
    chk("R7 enable low clears latch", reg_off, 0);
    chk("R7 target retained", target, 7);
    en = 1;
    hold(6'd33, 3);
    chk("R7 fresh count after enable", target, 7);
    hold(6'd33, 1);
    chk("R7 accepted after restart", target, 33);

    mode = 1;
    hold(6'b100011, 5);
    chk("R8 bit five masked in target", target, 3);
    pulses = 0;
    hold(6'b000011, 5);
    chk("R8 bit five ignored", pulses, 0);
    hold(6'h3F, 6);
    chk("R9 five-bit off match", reg_off, 1);
    chk("R9 off not target", target, 3);
    en = 0; tick(); en = 1; mode = 0;
    hold(6'h1F, 5);
    chk("R9 slew off code ordinary in direct mode", target, 31);
    chk("R9 no latch in direct mode", reg_off, 0);

    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      if (r < 30) vid = 6'($urandom_range(0, 63));
      else if (r < 34) vid = mode ? off_code_slew : off_code_direct;
      en = ($urandom_range(0, 49) != 0);
      if ($urandom_range(0, 199) == 0) mode = ~mode;
      tick();
    end
    finish_run();
  end
endmodule